// File: doc/BRIEF.md
# Static Memory Write-Cycle Controller

This block takes posted write requests from a pipelined system bus and replays them, one at a time, as clocked write cycles on an asynchronous static memory bus. A request's address and size arrive in one cycle and its write data in the cycle after. The block queues each completed request in a short FIFO, so the system side rarely has to wait.

Each memory cycle has four parts, and every edge falls on a system-clock boundary. First comes an address-only cycle. Next comes an asserted phase, in which chip select, byte-lane enables and write enable are all low and the data is driven. After that comes a one-cycle recovery, in which the strobes are high again while address and data stay on the bus. Last, the bus is released.

The upper two request-address bits pick one of four banks. Each bank has its own wait-state setting. An external active-low wait input can stretch the asserted phase past the programmed count.

Top module: `sram_write_ctl`

## Requirements
- R1: A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. The write data for that request is taken from `wrData` on the next clock edge, and any value on `wrData` in other cycles has no effect.
- R2: Each memory cycle opens with exactly one cycle in which `memAddr` carries request address bits [23:0]. In that cycle all `memCsN` bits, both `memBeN` bits and `memWeN` are high, and `memDataOe` is low.
- R3: In the next cycle, the selected chip select, the byte-lane enables and `memWeN` go low together. In the same cycle `memDataOe` goes high and `memData` carries the queued write data.
- R4: For a bank whose `waitCfg` field holds v, the asserted phase lasts at least N = v+1 cycles, so N ranges from 1 to 32.
- R5: The asserted phase ends after the first cycle h with h >= N in which `memWaitN` is sampled high at the closing clock edge. The phase therefore lasts max(N, cycles until wait goes high).
- R6: The cycle after the asserted phase is a recovery cycle. In it, chip selects, byte-lane enables and `memWeN` are high, while `memAddr`, `memData` and `memDataOe` keep their values.
- R7: The cycle after recovery releases the bus: `memAddr` and `memData` are zero and `memDataOe` is low.
- R8: Up to four requests may be held, counting queued entries plus one awaiting its data. `reqReady` is low only when that count is four. Writes reach the memory bus in acceptance order.
- R9: Request address bits [25:24] select the bank b. Only `memCsN[b]` is driven low.
- R10: A halfword write (`reqHalf`=1) drives `memBeN`=00. For a byte write, `memBeN`=10 when address bit 0 is 0 (low lane, data bits [7:0]) and 01 when it is 1 (high lane, data bits [15:8]). Data passes through unshifted.
- R11: After reset, `reqReady` is high, all strobes are high, `memDataOe` is low and `memAddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Write request address phase valid |
| reqAddr | input | 26 | Request address; [25:24] bank, [23:0] memory address |
| reqHalf | input | 1 | 1 = halfword write, 0 = byte write |
| wrData | input | 16 | Write data, presented one cycle after acceptance |
| reqReady | output | 1 | Block can accept an address phase this cycle |
| waitCfg | input | 20 | Four 5-bit wait settings, bank b at bits [5b+4:5b] |
| memWaitN | input | 1 | Active-low wait from the memory device |
| memAddr | output | 24 | Memory address bus |
| memData | output | 16 | Memory write data |
| memDataOe | output | 1 | Data bus drive enable |
| memCsN | output | 4 | Active-low chip selects, one per bank |
| memBeN | output | 2 | Active-low byte-lane enables |
| memWeN | output | 1 | Active-low write enable |

## Verification
The assertions assume two things about the inputs. First, `waitCfg` stays constant while a memory cycle is in flight, because the minimum-length check reads the live field of the bank that just finished. Second, the system side presents at most one address phase per cycle and only drives data in the cycle after an acceptance. The bench programs `waitCfg` once, before reset is released, and never changes it. Its driver only raises `reqValid` from a task that holds the request until `reqReady` is seen high. It changes `memWaitN` only while a chip select is low, and returns it high whenever the bus is idle.

// File: rtl/sram_write_pkg.sv
package sram_write_pkg;

  localparam int MEM_AW = 24;
  localparam int DATA_W = 16;
  localparam int BANK_W = 2;
  localparam int BANKS  = 1 << BANK_W;
  localparam int LANES  = DATA_W / 8;
  localparam int REQ_AW = MEM_AW + BANK_W;

  // one posted write, ready to be replayed on the memory bus
  typedef struct packed {
    logic [MEM_AW-1:0] addr;
    logic [BANK_W-1:0] bank;
    logic [LANES-1:0]  beN;
    logic [DATA_W-1:0] data;
  } wr_entry_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic popHead;     // load queue head into the bus registers
    logic selectOn;    // chip select, lane enables and write enable low
    logic driveData;   // data bus enabled
    logic releaseBus;  // clear the bus registers at end of cycle
  } path_stb_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HOLD,
    ST_RECOV
  } cyc_state_e;

endpackage

// File: rtl/sram_write_path.sv
module sram_write_path
  import sram_write_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [REQ_AW-1:0] reqAddr,
  input  logic              reqHalf,
  input  logic [DATA_W-1:0] wrData,
  input  path_stb_t         stb,
  output logic              reqReady,
  output logic              qEmpty,
  output logic [BANK_W-1:0] curBank,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              memDataOe,
  output logic [BANKS-1:0]  memCsN,
  output logic [LANES-1:0]  memBeN,
  output logic              memWeN
);

  localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CNT_W = $clog2(QDEPTH + 1);

  logic              pendValid;
  logic [REQ_AW-1:0] pendAddr;
  logic              pendHalf;
  logic              accept;
  wr_entry_t         newEntry;

  wr_entry_t         fifoMem [QDEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [CNT_W:0]    occupancy;

  wr_entry_t         cur;

  assign accept = reqValid && reqReady;

  // address phase register: data follows one cycle later
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendHalf  <= 1'b0;
    end else begin
      pendValid <= accept;
      if (accept) begin
        pendAddr <= reqAddr;
        pendHalf <= reqHalf;
      end
    end
  end

  always_comb begin
    newEntry.addr = pendAddr[MEM_AW-1:0];
    newEntry.bank = pendAddr[REQ_AW-1 -: BANK_W];
    newEntry.data = wrData;
    if (pendHalf)         newEntry.beN = '0;
    else if (pendAddr[0]) newEntry.beN = 2'b01;
    else                  newEntry.beN = 2'b10;
  end

  // posted-write queue
  always_ff @(posedge clk) begin
    if (pendValid) fifoMem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pendValid)
        wrPtr <= (wrPtr == PTR_W'(QDEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (stb.popHead)
        rdPtr <= (rdPtr == PTR_W'(QDEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      count <= count + CNT_W'(pendValid) - CNT_W'(stb.popHead);
    end
  end

  assign occupancy = {1'b0, count} + (CNT_W+1)'(pendValid);
  assign reqReady  = occupancy < (CNT_W+1)'(QDEPTH);
  assign qEmpty    = (count == '0);

  // bus-side holding registers
  always_ff @(posedge clk) begin
    if (!rstN)               cur <= '0;
    else if (stb.popHead)    cur <= fifoMem[rdPtr];
    else if (stb.releaseBus) cur <= '0;
  end

  assign curBank   = cur.bank;
  assign memAddr   = cur.addr;
  assign memDataOe = stb.driveData;
  assign memData   = stb.driveData ? cur.data : '0;
  assign memWeN    = ~stb.selectOn;
  assign memBeN    = stb.selectOn ? cur.beN : '1;

  for (genvar b = 0; b < BANKS; b++) begin : g_cs
    assign memCsN[b] = ~(stb.selectOn && (cur.bank == BANK_W'(b)));
  end

endmodule

// File: rtl/sram_write_seq.sv
module sram_write_seq
  import sram_write_pkg::*;
#(
  parameter int WCFG_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    qEmpty,
  input  logic [BANK_W-1:0]       curBank,
  input  logic [BANKS*WCFG_W-1:0] waitCfg,
  input  logic                    memWaitN,
  output path_stb_t               stb
);

  localparam int HCNT_W = WCFG_W + 1;

  cyc_state_e        state;
  logic [HCNT_W-1:0] holdCnt;
  logic [WCFG_W-1:0] cfgVal;
  logic [HCNT_W-1:0] needN;
  logic              holdDone;

  assign cfgVal   = waitCfg[curBank*WCFG_W +: WCFG_W];
  assign needN    = {1'b0, cfgVal} + HCNT_W'(1);
  assign holdDone = (holdCnt >= needN) && memWaitN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      holdCnt <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (!qEmpty) state <= ST_SETUP;
        ST_SETUP: begin
          state   <= ST_HOLD;
          holdCnt <= HCNT_W'(1);
        end
        ST_HOLD: begin
          if (holdDone)            state   <= ST_RECOV;
          else if (holdCnt < needN) holdCnt <= holdCnt + HCNT_W'(1);
        end
        ST_RECOV: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.popHead    = (state == ST_IDLE) && !qEmpty;
    stb.selectOn   = (state == ST_HOLD);
    stb.driveData  = (state == ST_HOLD) || (state == ST_RECOV);
    stb.releaseBus = (state == ST_RECOV);
  end

endmodule

// File: rtl/sram_write_ctl.sv
module sram_write_ctl
  import sram_write_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int WCFG_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [REQ_AW-1:0]       reqAddr,
  input  logic                    reqHalf,
  input  logic [DATA_W-1:0]       wrData,
  output logic                    reqReady,
  input  logic [BANKS*WCFG_W-1:0] waitCfg,
  input  logic                    memWaitN,
  output logic [MEM_AW-1:0]       memAddr,
  output logic [DATA_W-1:0]       memData,
  output logic                    memDataOe,
  output logic [BANKS-1:0]        memCsN,
  output logic [LANES-1:0]        memBeN,
  output logic                    memWeN
);

  path_stb_t         stb;
  logic              qEmpty;
  logic [BANK_W-1:0] curBank;

  sram_write_seq #(.WCFG_W(WCFG_W)) seq_i (
    .clk      (clk),
    .rstN     (rstN),
    .qEmpty   (qEmpty),
    .curBank  (curBank),
    .waitCfg  (waitCfg),
    .memWaitN (memWaitN),
    .stb      (stb)
  );

  sram_write_path #(.QDEPTH(QDEPTH)) path_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqAddr   (reqAddr),
    .reqHalf   (reqHalf),
    .wrData    (wrData),
    .stb       (stb),
    .reqReady  (reqReady),
    .qEmpty    (qEmpty),
    .curBank   (curBank),
    .memAddr   (memAddr),
    .memData   (memData),
    .memDataOe (memDataOe),
    .memCsN    (memCsN),
    .memBeN    (memBeN),
    .memWeN    (memWeN)
  );

endmodule

// File: rtl/sram_write_chk.sv
module sram_write_chk
  import sram_write_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int WCFG_W = 5
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqValid,
  input logic                    reqReady,
  input logic [BANKS*WCFG_W-1:0] waitCfg,
  input logic                    memWaitN,
  input logic [MEM_AW-1:0]       memAddr,
  input logic                    memDataOe,
  input logic [BANKS-1:0]        memCsN,
  input logic [LANES-1:0]        memBeN,
  input logic                    memWeN
);

  logic              csOn, csPrev, endPrev;
  logic [5:0]        holdLen;
  logic [BANK_W-1:0] bankNow, bankPrev;
  logic [3:0]        outst;
  logic [WCFG_W:0]   reqN;

  assign csOn = (memCsN != '1);
  assign reqN = {1'b0, waitCfg[bankPrev*WCFG_W +: WCFG_W]} + (WCFG_W+1)'(1);

  always_comb begin
    bankNow = '0;
    for (int b = 0; b < BANKS; b++)
      if (!memCsN[b]) bankNow = BANK_W'(b);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev   <= 1'b0;
      endPrev  <= 1'b0;
      holdLen  <= '0;
      bankPrev <= '0;
      outst    <= '0;
    end else begin
      csPrev  <= csOn;
      endPrev <= csPrev && !csOn;
      if (csOn) begin
        holdLen  <= (holdLen == 6'd63) ? holdLen : holdLen + 6'd1;
        bankPrev <= bankNow;
      end else if (!csPrev) begin
        holdLen <= '0;
      end
      outst <= outst + 4'(reqValid && reqReady) - 4'(csOn && !csPrev);
    end
  end

  p_setup_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    (csOn && !csPrev) |-> ($stable(memAddr) && $past(memWeN) && ($past(memBeN) == '1) && !$past(memDataOe)));

  p_strobes_together_r3: assert property (@(posedge clk) disable iff (!rstN)
    csOn |-> (!memWeN && (memBeN != '1) && memDataOe));

  p_min_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (csPrev && !csOn) |-> (holdLen >= 6'(reqN)));

  p_wait_seen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (csPrev && !csOn) |-> $past(memWaitN));

  p_recovery_r6: assert property (@(posedge clk) disable iff (!rstN)
    (csPrev && !csOn) |-> (memDataOe && $stable(memAddr) && memWeN && (memBeN == '1)));

  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    endPrev |-> (!memDataOe && (memAddr == '0)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    outst <= 4'(QDEPTH + 1));

  p_one_bank_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));

endmodule

bind sram_write_ctl sram_write_chk #(.QDEPTH(QDEPTH), .WCFG_W(WCFG_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .waitCfg   (waitCfg),
  .memWaitN  (memWaitN),
  .memAddr   (memAddr),
  .memDataOe (memDataOe),
  .memCsN    (memCsN),
  .memBeN    (memBeN),
  .memWeN    (memWeN)
);

// File: tb/sram_write_ctl_tb_top.sv
module sram_write_ctl_tb_top;

  typedef struct {
    logic [23:0] addr;
    int          bank;
    logic [1:0]  beN;
    logic [15:0] data;
    int          n;
    int          k;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [25:0] reqAddr = '0;
  logic        reqHalf = 1'b0;
  logic [15:0] wrData = 16'hBAD0;
  logic        reqReady;
  logic [19:0] waitCfg;
  logic        memWaitN = 1'b1;
  logic [23:0] memAddr;
  logic [15:0] memData;
  logic        memDataOe;
  logic [3:0]  memCsN;
  logic [1:0]  memBeN;
  logic        memWeN;

  int checks = 0;
  int failures = 0;
  int issued = 0;
  int completed = 0;
  bit finished = 1'b0;

  exp_t sbQ[$];
  exp_t curItem;
  bit   inCs = 1'b0;
  bit   relPend = 1'b0;
  int   hCnt = 0;
  logic [23:0] prevAddr = '0;
  bit   prevIdle = 1'b1;

  bit          havePrev = 1'b0;
  logic [15:0] prevData = '0;

  // bank 0: N=1, bank 1: N=4, bank 2: N=32, bank 3: N=8
  localparam int CFG0 = 0, CFG1 = 3, CFG2 = 31, CFG3 = 7;
  assign waitCfg = {5'(CFG3), 5'(CFG2), 5'(CFG1), 5'(CFG0)};

  always #10 clk = ~clk;

  sram_write_ctl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqHalf(reqHalf), .wrData(wrData), .reqReady(reqReady),
    .waitCfg(waitCfg), .memWaitN(memWaitN), .memAddr(memAddr),
    .memData(memData), .memDataOe(memDataOe), .memCsN(memCsN),
    .memBeN(memBeN), .memWeN(memWeN)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int cfgN(input int bank);
    case (bank)
      0: return CFG0 + 1;
      1: return CFG1 + 1;
      2: return CFG2 + 1;
      default: return CFG3 + 1;
    endcase
  endfunction

  // driver: call just after a negedge
  task automatic issue(input logic [25:0] a, input bit half, input logic [15:0] d,
                       input int k, output int stalls);
    exp_t e;
    reqValid = 1'b1;
    reqAddr  = a;
    reqHalf  = half;
    wrData   = havePrev ? prevData : 16'hBAD0;
    stalls   = 0;
    while (!reqReady) begin
      @(negedge clk);
      wrData = 16'hBAD0;
      stalls++;
    end
    e.addr = a[23:0];
    e.bank = int'(a[25:24]);
    e.beN  = half ? 2'b00 : (a[0] ? 2'b01 : 2'b10);
    e.data = d;
    e.n    = cfgN(e.bank);
    e.k    = k;
    sbQ.push_back(e);
    issued++;
    @(negedge clk);
    havePrev = 1'b1;
    prevData = d;
  endtask

  task automatic flush();
    reqValid = 1'b0;
    wrData   = havePrev ? prevData : 16'hBAD0;
    havePrev = 1'b0;
    @(negedge clk);
    wrData = 16'hBAD0;
  endtask

  task automatic waitIdle();
    while (sbQ.size() != 0 || inCs || relPend) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      bit csNow;
      csNow = (memCsN != 4'hF);
      if (relPend) begin
        check(memAddr == 24'h0, "R7", "released address", memAddr, 0);
        check(!memDataOe && memData == 16'h0, "R7", "released data oe", memDataOe, 0);
        relPend = 1'b0;
      end
      if (csNow && !inCs) begin
        if (sbQ.size() == 0) begin
          check(1'b0, "R8", "unexpected memory cycle", memAddr, 0);
          curItem.addr = memAddr; curItem.bank = 0; curItem.beN = memBeN;
          curItem.data = memData; curItem.n = 1; curItem.k = 0;
        end else begin
          curItem = sbQ.pop_front();
        end
        check(prevIdle && prevAddr == curItem.addr, "R2", "setup cycle address", prevAddr, curItem.addr);
        check(memCsN == ~(4'b1 << curItem.bank), "R9", "chip select", memCsN, ~(4'b1 << curItem.bank));
        check(memBeN == curItem.beN, "R10", "lane enables", memBeN, curItem.beN);
        check(!memWeN && memDataOe, "R3", "we and oe with cs", {memWeN, memDataOe}, 2'b01);
        check(memData == curItem.data, "R1", "pipelined write data", memData, curItem.data);
        inCs = 1'b1;
        hCnt = 1;
      end else if (csNow && inCs) begin
        hCnt++;
      end
      if (csNow) memWaitN = (hCnt > curItem.k);
      if (!csNow && inCs) begin
        int expLen;
        expLen = (curItem.n > curItem.k + 1) ? curItem.n : curItem.k + 1;
        check(hCnt == expLen, (curItem.k + 1 > curItem.n) ? "R5" : "R4",
              "asserted phase length", hCnt, expLen);
        check(memAddr == curItem.addr && memDataOe && memData == curItem.data,
              "R6", "recovery keeps address and data", memAddr, curItem.addr);
        check(memWeN && memBeN == 2'b11, "R6", "recovery strobes high", {memWeN, memBeN}, 3'b111);
        inCs = 1'b0;
        relPend = 1'b1;
        memWaitN = 1'b1;
        completed++;
      end
      prevAddr = memAddr;
      prevIdle = (memCsN == 4'hF) && memWeN && (memBeN == 2'b11) && !memDataOe;
    end
  end

  initial begin
    int st;
    int stl[6];
    repeat (5) @(negedge clk);
    check(reqReady == 1'b1, "R11", "ready after reset", reqReady, 1);
    check(memCsN == 4'hF && memWeN && memBeN == 2'b11, "R11", "strobes idle",
          {memCsN, memWeN, memBeN}, 7'h7F);
    check(!memDataOe && memAddr == 24'h0, "R11", "bus released", memAddr, 0);
    rstN = 1'b1;
    @(negedge clk);

    // single halfword write, bank 0 (N=1)
    issue(26'h0_12_3456, 1'b1, 16'hA55A, 0, st);
    check(st == 0, "R1", "accepted without stall", st, 0);
    flush();
    waitIdle();

    // byte writes in bank 1, even and odd address
    issue(26'h1_00_0010, 1'b0, 16'h00C3, 0, st);
    issue(26'h1_00_0011, 1'b0, 16'h3C00, 0, st);
    flush();
    waitIdle();

    // wait input extends beyond N (N=4, wait low 7 cycles)
    issue(26'h1_AB_CDE0, 1'b1, 16'h1234, 7, st);
    flush();
    waitIdle();
    // wait input shorter than N: N wins
    issue(26'h1_AB_CDE2, 1'b1, 16'h5678, 2, st);
    flush();
    waitIdle();

    // bank 3 (N=8) and bank 2 (N=32, the maximum)
    issue(26'h3_FF_FFFE, 1'b1, 16'hBEEF, 0, st);
    issue(26'h2_00_0001, 1'b0, 16'hF00D, 0, st);
    flush();
    waitIdle();

    // back-pressure: six back-to-back writes into bank 2
    for (int i = 0; i < 6; i++)
      issue(26'h2_40_0000 + 26'(2 * i), 1'b1, 16'h7000 + 16'(i), 0, stl[i]);
    flush();
    for (int i = 0; i < 5; i++)
      check(stl[i] == 0, "R8", "no stall while space remains", stl[i], 0);
    check(stl[5] > 0, "R8", "stall when four held", stl[5], 1);
    waitIdle();
    check(completed == issued, "R8", "all writes completed in order", completed, issued);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", completed, issued);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule